// File: doc/BRIEF.md
# Thread Frame Allocator with Input Countdown

This block hands out fixed-size thread frames from a pool and tracks, for each frame in use, how many inputs its thread still needs. A creation request takes a frame index from a last-in-first-out stack of free indexes. That index becomes the thread's frame pointer. The request also records the thread's starting instruction pointer and the number of inputs the thread expects. A release request returns an index to the stack. Both requests finish two cycles after they are presented, and a new request of each kind may be presented in every cycle.

Every input delivery names a frame and lowers that frame's remaining input count by one. When the count reaches zero, the thread is ready to run. The block then queues an enable event that carries the frame pointer and the instruction pointer. A thread created with no inputs at all is queued as soon as its frame is assigned. Events wait in a small queue and leave through a valid/ready pair, one per cycle. Frame contents and the movement of data into registers are handled elsewhere; this block keeps only the control state.

Top module: `frame_sync_alloc`

## Requirements
- R1: After reset, `alloc_done_o`, `alloc_err_o` and `ev_valid_o` are 0, and successive creation requests receive frame indexes 0, 1, 2, ... in ascending order.
- R2: A creation request sampled at clock edge k reports its result at edge k+2. The result is a one-cycle `alloc_done_o` pulse together with the frame index on `alloc_fp_o`. Nothing is reported at edge k+1.
- R3: Released indexes are reused last-in-first-out: the next creation receives the index released most recently.
- R4: A creation that finds no free index raises `alloc_err_o` for one cycle instead of `alloc_done_o`, and it changes neither the stack nor any frame. A later release followed by a creation hands back exactly the released index.
- R5: A delivery to a frame whose thread is still waiting lowers its count by one. The delivery that brings the count from 1 to 0 queues one enable event with that frame's index and recorded instruction pointer. An earlier delivery queues nothing.
- R6: A delivery to a frame that is free, or whose thread has already been enabled, has no effect and queues no event.
- R7: A creation with an input count of 0 queues its enable event at the same edge at which `alloc_done_o` rises.
- R8: A delivery that lands at the same edge as a creation completing for a different frame is applied in full.
- R9: Enable events leave in the order they were queued, at most one per cycle, and stay unchanged on the outputs while `ev_ready_i` is low. If a delivery and a zero-count creation both queue an event at the same edge, the delivery's event goes first.
- R10: If a release and a creation complete at the same edge, the creation receives the released index, even when the stack is otherwise empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req_i | input | 1 | Create a thread (take a frame) |
| alloc_ip_i | input | IP_W | Starting instruction pointer of the new thread |
| alloc_cnt_i | input | CNT_W | Number of inputs the new thread waits for |
| alloc_done_o | output | 1 | Creation succeeded (one-cycle pulse) |
| alloc_err_o | output | 1 | Creation failed, no free frame (one-cycle pulse) |
| alloc_fp_o | output | $clog2(NUM_FRAMES) | Frame index given to the last successful creation |
| free_req_i | input | 1 | Release a frame |
| free_fp_i | input | $clog2(NUM_FRAMES) | Index of the frame to release |
| dec_req_i | input | 1 | Input delivery to a frame |
| dec_fp_i | input | $clog2(NUM_FRAMES) | Index of the frame receiving the input |
| ev_valid_o | output | 1 | An enable event is waiting |
| ev_fp_o | output | $clog2(NUM_FRAMES) | Frame index of the waiting event |
| ev_ip_o | output | IP_W | Instruction pointer of the waiting event |
| ev_ready_i | input | 1 | Consumer takes the waiting event |

## Verification
Two pairs of functions can fall in the same cycle. The first is an input delivery landing on the edge at which a creation completes. The second is a release completing together with a creation. The bench provokes the first pair by driving a delivery one cycle after the creation request. With a zero-count creation it checks that both events are queued with the delivery's event first. With a nonzero-count creation it checks that the delivery was counted: the target frame must enable after exactly the number of further deliveries that remain. For the second pair, the bench presents a release and a creation on the same cycle while the stack is empty and expects the released index back. A following creation must then fail, which shows the stack was not disturbed.

// File: rtl/fsa_pkg.sv
package fsa_pkg;
    localparam int FSA_FRAMES_DEF = 8;
    localparam int FSA_IP_W_DEF   = 16;
    localparam int FSA_CNT_W_DEF  = 4;
endpackage

// File: rtl/fsa_free_stack.sv
module fsa_free_stack #(
    parameter int NUM_FRAMES = fsa_pkg::FSA_FRAMES_DEF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pop_i,
    input  logic                          push_i,
    input  logic [$clog2(NUM_FRAMES)-1:0] push_idx_i,
    output logic                          pop_ok_o,
    output logic [$clog2(NUM_FRAMES)-1:0] pop_idx_o
);
    localparam int FP_W = $clog2(NUM_FRAMES);
    localparam int SP_W = $clog2(NUM_FRAMES + 1);

    typedef struct packed {
        logic [NUM_FRAMES-1:0][FP_W-1:0] slot;
        logic [SP_W-1:0]                 sp;
    } stk_t;

    stk_t stk_d, stk_q;
    logic [FP_W-1:0] top_idx;
    logic [FP_W-1:0] put_idx;

    always_comb begin
        stk_d     = stk_q;
        pop_ok_o  = 1'b0;
        pop_idx_o = '0;
        top_idx   = FP_W'(stk_q.sp - 1'b1);
        put_idx   = FP_W'(stk_q.sp);
        if (pop_i && push_i) begin
            // index returned and taken in the same cycle bypasses the stack
            pop_ok_o  = 1'b1;
            pop_idx_o = push_idx_i;
        end else if (pop_i) begin
            if (stk_q.sp != '0) begin
                pop_ok_o  = 1'b1;
                pop_idx_o = stk_q.slot[top_idx];
                stk_d.sp  = stk_q.sp - 1'b1;
            end
        end else if (push_i && (stk_q.sp != SP_W'(NUM_FRAMES))) begin
            stk_d.slot[put_idx] = push_idx_i;
            stk_d.sp            = stk_q.sp + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_FRAMES; i++) begin
                stk_q.slot[i] <= FP_W'(NUM_FRAMES - 1 - i);
            end
            stk_q.sp <= SP_W'(NUM_FRAMES);
        end else begin
            stk_q <= stk_d;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        stk_q.sp <= SP_W'(NUM_FRAMES)); // R3
endmodule

// File: rtl/fsa_sync_table.sv
module fsa_sync_table #(
    parameter int NUM_FRAMES = fsa_pkg::FSA_FRAMES_DEF,
    parameter int IP_W       = fsa_pkg::FSA_IP_W_DEF,
    parameter int CNT_W      = fsa_pkg::FSA_CNT_W_DEF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_i,
    input  logic [$clog2(NUM_FRAMES)-1:0] wr_fp_i,
    input  logic [IP_W-1:0]               wr_ip_i,
    input  logic [CNT_W-1:0]              wr_cnt_i,
    input  logic                          clr_i,
    input  logic [$clog2(NUM_FRAMES)-1:0] clr_fp_i,
    input  logic                          dec_i,
    input  logic [$clog2(NUM_FRAMES)-1:0] dec_fp_i,
    output logic                          fire_o,
    output logic [$clog2(NUM_FRAMES)-1:0] fire_fp_o,
    output logic [IP_W-1:0]               fire_ip_o
);
    typedef struct packed {
        logic [NUM_FRAMES-1:0]            waiting;
        logic [NUM_FRAMES-1:0][CNT_W-1:0] cnt;
        logic [NUM_FRAMES-1:0][IP_W-1:0]  ip;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d     = tbl_q;
        fire_o    = 1'b0;
        fire_fp_o = dec_fp_i;
        fire_ip_o = tbl_q.ip[dec_fp_i];
        if (dec_i && tbl_q.waiting[dec_fp_i]) begin
            tbl_d.cnt[dec_fp_i] = tbl_q.cnt[dec_fp_i] - 1'b1;
            if (tbl_q.cnt[dec_fp_i] == CNT_W'(1)) begin
                tbl_d.waiting[dec_fp_i] = 1'b0;
                fire_o                  = 1'b1;
            end
        end
        if (clr_i) begin
            tbl_d.waiting[clr_fp_i] = 1'b0;
        end
        if (wr_i) begin
            tbl_d.waiting[wr_fp_i] = (wr_cnt_i != '0);
            tbl_d.cnt[wr_fp_i]     = wr_cnt_i;
            tbl_d.ip[wr_fp_i]      = wr_ip_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_chk
        AST_WAIT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
            tbl_q.waiting[g] |-> (tbl_q.cnt[g] != '0)); // R5
    end
endmodule

// File: rtl/fsa_event_fifo.sv
module fsa_event_fifo #(
    parameter int NUM_FRAMES = fsa_pkg::FSA_FRAMES_DEF,
    parameter int IP_W       = fsa_pkg::FSA_IP_W_DEF,
    parameter int DEPTH      = NUM_FRAMES
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          a_v_i,
    input  logic [$clog2(NUM_FRAMES)-1:0] a_fp_i,
    input  logic [IP_W-1:0]               a_ip_i,
    input  logic                          b_v_i,
    input  logic [$clog2(NUM_FRAMES)-1:0] b_fp_i,
    input  logic [IP_W-1:0]               b_ip_i,
    output logic                          ev_valid_o,
    output logic [$clog2(NUM_FRAMES)-1:0] ev_fp_o,
    output logic [IP_W-1:0]               ev_ip_o,
    input  logic                          ev_ready_i
);
    localparam int FP_W = $clog2(NUM_FRAMES);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW   = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][FP_W-1:0] fp;
        logic [DEPTH-1:0][IP_W-1:0] ip;
        logic [PW-1:0]              rp;
        logic [PW-1:0]              wp;
        logic [CW-1:0]              lvl;
    } fifo_t;

    fifo_t fq_d, fq_q;
    logic [CW-1:0] lvl;
    logic          drop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        fq_d = fq_q;
        drop = 1'b0;
        lvl  = fq_q.lvl;
        if ((fq_q.lvl != '0) && ev_ready_i) begin
            fq_d.rp = step(fq_q.rp);
            lvl     = lvl - 1'b1;
        end
        // delivery event enters ahead of the zero-count creation event
        if (a_v_i) begin
            if (lvl < CW'(DEPTH)) begin
                fq_d.fp[fq_d.wp] = a_fp_i;
                fq_d.ip[fq_d.wp] = a_ip_i;
                fq_d.wp          = step(fq_d.wp);
                lvl              = lvl + 1'b1;
            end else begin
                drop = 1'b1;
            end
        end
        if (b_v_i) begin
            if (lvl < CW'(DEPTH)) begin
                fq_d.fp[fq_d.wp] = b_fp_i;
                fq_d.ip[fq_d.wp] = b_ip_i;
                fq_d.wp          = step(fq_d.wp);
                lvl              = lvl + 1'b1;
            end else begin
                drop = 1'b1;
            end
        end
        fq_d.lvl = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fq_q <= '0;
        end else begin
            fq_q <= fq_d;
        end
    end

    assign ev_valid_o = (fq_q.lvl != '0);
    assign ev_fp_o    = fq_q.fp[fq_q.rp];
    assign ev_ip_o    = fq_q.ip[fq_q.rp];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !drop); // R9
    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid_o && !ev_ready_i) |=> (ev_valid_o && $stable(ev_fp_o) && $stable(ev_ip_o))); // R9
endmodule

// File: rtl/frame_sync_alloc.sv
module frame_sync_alloc #(
    parameter int NUM_FRAMES = fsa_pkg::FSA_FRAMES_DEF,
    parameter int IP_W       = fsa_pkg::FSA_IP_W_DEF,
    parameter int CNT_W      = fsa_pkg::FSA_CNT_W_DEF,
    parameter int EV_DEPTH   = NUM_FRAMES
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_req_i,
    input  logic [IP_W-1:0]               alloc_ip_i,
    input  logic [CNT_W-1:0]              alloc_cnt_i,
    output logic                          alloc_done_o,
    output logic                          alloc_err_o,
    output logic [$clog2(NUM_FRAMES)-1:0] alloc_fp_o,
    input  logic                          free_req_i,
    input  logic [$clog2(NUM_FRAMES)-1:0] free_fp_i,
    input  logic                          dec_req_i,
    input  logic [$clog2(NUM_FRAMES)-1:0] dec_fp_i,
    output logic                          ev_valid_o,
    output logic [$clog2(NUM_FRAMES)-1:0] ev_fp_o,
    output logic [IP_W-1:0]               ev_ip_o,
    input  logic                          ev_ready_i
);
    localparam int FP_W = $clog2(NUM_FRAMES);

    typedef struct packed {
        logic             a_v;
        logic [IP_W-1:0]  a_ip;
        logic [CNT_W-1:0] a_cnt;
        logic             f_v;
        logic [FP_W-1:0]  f_fp;
        logic             done;
        logic             err;
        logic [FP_W-1:0]  fp;
    } pipe_t;

    pipe_t pp_d, pp_q;

    logic            pop_ok;
    logic [FP_W-1:0] pop_idx;
    logic            tbl_wr;
    logic            dec_fire;
    logic [FP_W-1:0] dec_fire_fp;
    logic [IP_W-1:0] dec_fire_ip;
    logic            zero_fire;

    fsa_free_stack #(.NUM_FRAMES(NUM_FRAMES)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .pop_i      (pp_q.a_v),
        .push_i     (pp_q.f_v),
        .push_idx_i (pp_q.f_fp),
        .pop_ok_o   (pop_ok),
        .pop_idx_o  (pop_idx)
    );

    fsa_sync_table #(.NUM_FRAMES(NUM_FRAMES), .IP_W(IP_W), .CNT_W(CNT_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (tbl_wr),
        .wr_fp_i   (pop_idx),
        .wr_ip_i   (pp_q.a_ip),
        .wr_cnt_i  (pp_q.a_cnt),
        .clr_i     (pp_q.f_v),
        .clr_fp_i  (pp_q.f_fp),
        .dec_i     (dec_req_i),
        .dec_fp_i  (dec_fp_i),
        .fire_o    (dec_fire),
        .fire_fp_o (dec_fire_fp),
        .fire_ip_o (dec_fire_ip)
    );

    fsa_event_fifo #(.NUM_FRAMES(NUM_FRAMES), .IP_W(IP_W), .DEPTH(EV_DEPTH)) u_evq (
        .clk        (clk),
        .rst_n      (rst_n),
        .a_v_i      (dec_fire),
        .a_fp_i     (dec_fire_fp),
        .a_ip_i     (dec_fire_ip),
        .b_v_i      (zero_fire),
        .b_fp_i     (pop_idx),
        .b_ip_i     (pp_q.a_ip),
        .ev_valid_o (ev_valid_o),
        .ev_fp_o    (ev_fp_o),
        .ev_ip_o    (ev_ip_o),
        .ev_ready_i (ev_ready_i)
    );

    always_comb begin
        pp_d       = pp_q;
        pp_d.a_v   = alloc_req_i;
        pp_d.a_ip  = alloc_ip_i;
        pp_d.a_cnt = alloc_cnt_i;
        pp_d.f_v   = free_req_i;
        pp_d.f_fp  = free_fp_i;
        tbl_wr     = pp_q.a_v && pop_ok;
        zero_fire  = tbl_wr && (pp_q.a_cnt == '0);
        pp_d.done  = tbl_wr;
        pp_d.err   = pp_q.a_v && !pop_ok;
        if (tbl_wr) begin
            pp_d.fp = pop_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pp_q <= '0;
        end else begin
            pp_q <= pp_d;
        end
    end

    assign alloc_done_o = pp_q.done;
    assign alloc_err_o  = pp_q.err;
    assign alloc_fp_o   = pp_q.fp;

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_done_o || alloc_err_o) |-> $past(alloc_req_i, 2)); // R2
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_done_o && alloc_err_o)); // R4
    AST_ZERO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_done_o && ($past(alloc_cnt_i, 2) == '0)) |-> ev_valid_o); // R7
endmodule

// File: tb/frame_sync_alloc_bench.sv
module frame_sync_alloc_bench;
    localparam int NF   = 8;
    localparam int IPW  = 16;
    localparam int CW   = 4;
    localparam int FPW  = $clog2(NF);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           alloc_req = 1'b0;
    logic [IPW-1:0] alloc_ip = '0;
    logic [CW-1:0]  alloc_cnt = '0;
    logic           alloc_done, alloc_err;
    logic [FPW-1:0] alloc_fp;
    logic           free_req = 1'b0;
    logic [FPW-1:0] free_fp = '0;
    logic           dec_req = 1'b0;
    logic [FPW-1:0] dec_fp = '0;
    logic           ev_valid;
    logic [FPW-1:0] ev_fp;
    logic [IPW-1:0] ev_ip;
    logic           ev_ready = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    frame_sync_alloc #(.NUM_FRAMES(NF), .IP_W(IPW), .CNT_W(CW)) u_frame_sync_alloc (
        .clk(clk), .rst_n(rst_n),
        .alloc_req_i(alloc_req), .alloc_ip_i(alloc_ip), .alloc_cnt_i(alloc_cnt),
        .alloc_done_o(alloc_done), .alloc_err_o(alloc_err), .alloc_fp_o(alloc_fp),
        .free_req_i(free_req), .free_fp_i(free_fp),
        .dec_req_i(dec_req), .dec_fp_i(dec_fp),
        .ev_valid_o(ev_valid), .ev_fp_o(ev_fp), .ev_ip_o(ev_ip), .ev_ready_i(ev_ready)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // creation with an optional delivery landing on the completion edge and an optional release alongside
    task automatic alloc_ex(input logic [IPW-1:0] ip, input logic [CW-1:0] cnt,
                            input logic d_en, input logic [FPW-1:0] d_fp,
                            input logic f_en, input logic [FPW-1:0] f_fp,
                            input logic exp_ok, input logic [FPW-1:0] exp_fp, input string tag);
        alloc_req = 1'b1; alloc_ip = ip; alloc_cnt = cnt;
        free_req = f_en; free_fp = f_fp;
        tick();
        alloc_req = 1'b0; free_req = 1'b0;
        check({"R2 no result after one cycle ", tag}, {31'd0, alloc_done | alloc_err}, 32'd0);
        dec_req = d_en; dec_fp = d_fp;
        tick();
        dec_req = 1'b0;
        check({tag, " done"}, {31'd0, alloc_done}, {31'd0, exp_ok});
        check({tag, " err"}, {31'd0, alloc_err}, {31'd0, !exp_ok});
        if (exp_ok) check({tag, " fp"}, {29'd0, alloc_fp}, {29'd0, exp_fp});
    endtask

    task automatic do_alloc(input logic [IPW-1:0] ip, input logic [CW-1:0] cnt,
                            input logic exp_ok, input logic [FPW-1:0] exp_fp, input string tag);
        alloc_ex(ip, cnt, 1'b0, '0, 1'b0, '0, exp_ok, exp_fp, tag);
    endtask

    task automatic do_free(input logic [FPW-1:0] fp);
        free_req = 1'b1; free_fp = fp;
        tick();
        free_req = 1'b0;
        tick();
    endtask

    task automatic do_dec(input logic [FPW-1:0] fp);
        dec_req = 1'b1; dec_fp = fp;
        tick();
        dec_req = 1'b0;
    endtask

    task automatic pop_ev(input logic [FPW-1:0] fp, input logic [IPW-1:0] ip, input string tag);
        check({tag, " ev_valid"}, {31'd0, ev_valid}, 32'd1);
        check({tag, " ev_fp"}, {29'd0, ev_fp}, {29'd0, fp});
        check({tag, " ev_ip"}, {16'd0, ev_ip}, {16'd0, ip});
        ev_ready = 1'b1;
        tick();
        ev_ready = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset alloc_done", {31'd0, alloc_done}, 32'd0);
        check("R1 reset alloc_err", {31'd0, alloc_err}, 32'd0);
        check("R1 reset ev_valid", {31'd0, ev_valid}, 32'd0);
    endtask

    task automatic t_first_allocs();
        do_alloc(16'hA000, 4'd2, 1'b1, 3'd0, "R1 R2 first alloc");
        do_alloc(16'hB000, 4'd1, 1'b1, 3'd1, "R1 second alloc");
        do_alloc(16'hC000, 4'd3, 1'b1, 3'd2, "R1 third alloc");
    endtask

    task automatic t_countdown();
        do_dec(3'd0);
        check("R5 no event at count 1", {31'd0, ev_valid}, 32'd0);
        do_dec(3'd0);
        pop_ev(3'd0, 16'hA000, "R5 enable at zero");
        check("R5 queue empty after pop", {31'd0, ev_valid}, 32'd0);
    endtask

    task automatic t_ignored();
        do_dec(3'd0);
        check("R6 enabled frame ignores delivery", {31'd0, ev_valid}, 32'd0);
        do_dec(3'd5);
        check("R6 free frame ignores delivery", {31'd0, ev_valid}, 32'd0);
    endtask

    task automatic t_zero_count();
        do_alloc(16'h00D3, 4'd0, 1'b1, 3'd3, "R7 zero-count alloc");
        check("R7 immediate event", {31'd0, ev_valid}, 32'd1);
        tick(); tick(); tick();
        pop_ev(3'd3, 16'h00D3, "R9 R7 event held while not ready");
    endtask

    task automatic t_concurrent();
        // frame1 reaches zero on the same edge a zero-count creation completes
        alloc_ex(16'h0E44, 4'd0, 1'b1, 3'd1, 1'b0, '0, 1'b1, 3'd4, "R8 alloc with delivery");
        pop_ev(3'd1, 16'hB000, "R9 delivery event first");
        pop_ev(3'd4, 16'h0E44, "R9 creation event second");
        check("R9 queue drained", {31'd0, ev_valid}, 32'd0);
        // frame2 (count 3) takes one delivery alongside a nonzero creation
        alloc_ex(16'h0F55, 4'd2, 1'b1, 3'd2, 1'b0, '0, 1'b1, 3'd5, "R8 alloc with count-3 delivery");
        do_dec(3'd2);
        check("R8 count 1 left, no event", {31'd0, ev_valid}, 32'd0);
        do_dec(3'd2);
        pop_ev(3'd2, 16'hC000, "R8 concurrent delivery was counted");
    endtask

    task automatic t_exhaust();
        do_alloc(16'h0106, 4'd1, 1'b1, 3'd6, "R1 alloc 6");
        do_alloc(16'h0107, 4'd1, 1'b1, 3'd7, "R1 alloc 7");
        do_alloc(16'h0999, 4'd1, 1'b0, 3'd0, "R4 empty pool");
        do_free(3'd3);
        do_alloc(16'h0333, 4'd1, 1'b1, 3'd3, "R4 state intact after error");
        do_alloc(16'h0998, 4'd1, 1'b0, 3'd0, "R4 empty again");
    endtask

    task automatic t_lifo();
        do_free(3'd5);
        do_free(3'd0);
        do_alloc(16'h0500, 4'd1, 1'b1, 3'd0, "R3 last freed first");
        do_alloc(16'h0501, 4'd1, 1'b1, 3'd5, "R3 earlier freed next");
    endtask

    task automatic t_bypass();
        alloc_ex(16'h0777, 4'd1, 1'b0, '0, 1'b1, 3'd6, 1'b1, 3'd6, "R10 release and create together");
        do_alloc(16'h0997, 4'd1, 1'b0, 3'd0, "R10 stack untouched");
        do_dec(3'd6);
        pop_ev(3'd6, 16'h0777, "R5 R10 reused frame enables");
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_first_allocs();
        t_countdown();
        t_ignored();
        t_zero_count();
        t_concurrent();
        t_exhaust();
        t_lifo();
        t_bypass();
        tick();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule